// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects level-sensitive interrupt reports from PCI devices and drives them onto sixteen legacy interrupt-controller request lines. A device report names the device (a small index), the slot it sits in, the pin it uses (INTA to INTD) and the level it now drives. The block rotates the pin by the slot number to pick one of four shared interrupt lanes. It keeps one level bit per device on each lane, so several devices can share a lane without losing one another's requests.

Four byte-wide steering registers sit behind a small register port. Each one names the legacy line that one lane drives, or parks the lane when its value is sixteen or more. Each legacy output is the OR of every lane steered to it, so two lanes can share one line. The outputs are computed combinationally from the registered state, so a steering change shows on the lines one cycle after the write, with no new device report needed.

Top module: `pirq_router`

## Requirements
- R1: The lane for a report is (pin + slot − 1) modulo 4, where pin is 0 for INTA through 3 for INTD and slot is the device/function number shifted right by three (slot 0 maps INTA to lane 3).
- R2: A report with evt_valid high updates only the level bit of that device on the computed lane, one clock edge later. Bits of other devices and of other lanes keep their value, and with evt_valid low no bit changes.
- R3: A lane is active while at least one device bit held on it is set. It goes inactive only when the last of them is cleared.
- R4: A write with reg_wr high to address 0x60 + n (n = 0..3) loads reg_wdata into the steering register of lane n at the next edge. Writes to any other address change no register.
- R5: reg_rdata returns the steering register of lane n while reg_addr is 0x60 + n, in the same cycle, and returns 0 for any other address.
- R6: A lane whose steering value is 16 or more drives no output line, whatever its level.
- R7: Output line L (bit L of irq_out) is the OR of every active lane whose steering value equals L, so several lanes can drive one line.
- R8: A synchronous active-low reset clears every device level bit, loads every steering register with 0x80 (all lanes parked) and leaves irq_out at 0.
- R9: A steering write takes effect on irq_out in the cycle after the write edge, with no device report in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | A device level report is present this cycle |
| evt_dev | input | DEV_W | Index of the reporting device |
| evt_slot | input | SLOT_W | Slot number of the reporting device (devfn >> 3) |
| evt_pin | input | 2 | Interrupt pin, 0 = INTA .. 3 = INTD |
| evt_level | input | 1 | Level now driven by the device on that pin |
| reg_wr | input | 1 | Byte write strobe for the register port |
| reg_addr | input | 8 | Register port byte address |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data, combinational on reg_addr |
| irq_out | output | NUM_LINES | Level-sensitive legacy interrupt request lines |

## Verification
The bench aims at slot wrap-around: slot 0 must land INTA on lane 3 and slot 31 must wrap to lane 0. A design that drops the minus one or the modulo would light the wrong line. It releases one of two devices that share a lane and checks that the line stays up; a design that keeps one bit per lane instead of one per device would drop it early. It steers two lanes onto one line, then parks one of them with a value of exactly 16. It also writes just past the register window. Wrong OR logic, an off-by-one range test or a loose address decode would show as a stuck, missing or extra line, or as a changed read-back.

// File: rtl/pirq_pkg.sv
// Package: shared sizes and types for the interrupt pin router.
// Assumes four lanes indexed by a 2-bit pin code (INTA = 0).
package pirq_pkg;
    localparam int LANES     = 4;
    localparam int PIN_W     = 2;
    localparam int ROUTE_W   = 8;
    localparam logic [ROUTE_W-1:0] ROUTE_PARKED = 8'h80;

    typedef logic [ROUTE_W-1:0] route_t;
    typedef logic [PIN_W-1:0]   lane_t;
endpackage

// File: rtl/pirq_swizzle.sv
// Pin rotation: turns a (pin, slot) pair into a shared lane number.
// Assumes the lane count is a power of two equal to 2**PIN_W, so the
// modulo is a plain truncation and "minus one" is "plus LANES-1".
module pirq_swizzle
    import pirq_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic [PIN_W-1:0]  pin,
    input  logic [SLOT_W-1:0] slot,
    output lane_t             lane
);
    localparam lane_t MINUS_ONE = lane_t'(LANES - 1);

    // Add the low slot bits and the wrapped -1, keep PIN_W bits.
    always_comb begin
        lane = pin + slot[PIN_W-1:0] + MINUS_ONE;
    end
endmodule

// File: rtl/pirq_level_store.sv
// Level store: one bit per (lane, device); a report rewrites one bit.
// Assumes reports are already mapped to a lane. A lane is active while
// any of its device bits is set.
module pirq_level_store
    import pirq_pkg::*;
#(
    parameter int NUM_DEV = 4,
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic [DEV_W-1:0]         dev,
    input  lane_t                    lane,
    input  logic                     level,
    output logic [LANES-1:0]         active,
    output logic [LANES*NUM_DEV-1:0] lvl_flat
);
    logic [LANES-1:0][NUM_DEV-1:0] bits;

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            // Hold or rewrite the bit of device d on lane p.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bits[p][d] <= 1'b0;
                end else if (upd && lane == lane_t'(p) && dev == DEV_W'(d)) begin
                    bits[p][d] <= level;
                end
            end
            assign lvl_flat[p*NUM_DEV + d] = bits[p][d];
        end
        // Lane level is the OR of its device bits.
        assign active[p] = |bits[p];
    end
endmodule

// File: rtl/pirq_route_regs.sv
// Steering registers: one byte per lane at BASE + lane, with byte
// writes and a combinational read-back. Assumes single-byte accesses;
// addresses outside the window read as zero and ignore writes.
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [7:0]               addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    output logic [LANES*ROUTE_W-1:0] route_flat
);
    route_t route [LANES];

    for (genvar p = 0; p < LANES; p++) begin : g_reg
        localparam logic [7:0] MY_ADDR = BASE + 8'(p);
        // Load this lane's register on a matching byte write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route[p] <= ROUTE_PARKED;
            end else if (wr && addr == MY_ADDR) begin
                route[p] <= route_t'(wdata);
            end
        end
        assign route_flat[p*ROUTE_W +: ROUTE_W] = route[p];
    end

    // Return the addressed register, zero outside the window.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < LANES; p++) begin
            if (addr == BASE + 8'(p)) rdata = 8'(route[p]);
        end
    end
endmodule

// File: rtl/pirq_line_merge.sv
// Line merge: each legacy line is the OR of the active lanes steered to
// it. A steering value at or above NUM_LINES equals no line index, so a
// parked lane drops out without a separate range test.
module pirq_line_merge
    import pirq_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic [LANES-1:0]         active,
    input  logic [LANES*ROUTE_W-1:0] route_flat,
    output logic [NUM_LINES-1:0]     irq
);
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [LANES-1:0] hit;
        for (genvar p = 0; p < LANES; p++) begin : g_src
            assign hit[p] = active[p] &&
                (route_flat[p*ROUTE_W +: ROUTE_W] == ROUTE_W'(l));
        end
        assign irq[l] = |hit;
    end
endmodule

// File: rtl/pirq_router.sv
// Top: PCI interrupt pin router. Rotates device pins onto four lanes,
// keeps per-device levels per lane and steers lanes to legacy lines.
// Assumes NUM_LINES <= 256 so a line number fits a steering byte.
module pirq_router
    import pirq_pkg::*;
#(
    parameter int NUM_DEV      = 4,
    parameter int SLOT_W       = 5,
    parameter int NUM_LINES    = 16,
    parameter logic [7:0] BASE = 8'h60,
    localparam int DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [DEV_W-1:0]     evt_dev,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic [PIN_W-1:0]     evt_pin,
    input  logic                 evt_level,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);
    lane_t                    evt_lane;
    logic [LANES-1:0]         lane_active;
    logic [LANES*NUM_DEV-1:0] lvl_flat;
    logic [LANES*ROUTE_W-1:0] route_flat;

    pirq_swizzle #(.SLOT_W(SLOT_W)) u_swz (
        .pin  (evt_pin),
        .slot (evt_slot),
        .lane (evt_lane)
    );

    pirq_level_store #(.NUM_DEV(NUM_DEV)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (evt_valid),
        .dev      (evt_dev),
        .lane     (evt_lane),
        .level    (evt_level),
        .active   (lane_active),
        .lvl_flat (lvl_flat)
    );

    pirq_route_regs #(.BASE(BASE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .route_flat (route_flat)
    );

    pirq_line_merge #(.NUM_LINES(NUM_LINES)) u_merge (
        .active     (lane_active),
        .route_flat (route_flat),
        .irq        (irq_out)
    );
endmodule

// File: rtl/pirq_router_chk.sv
// Checker for pirq_router: relates the register port, the level store
// and the output lines over time. Bound to every pirq_router instance.
module pirq_router_chk
    import pirq_pkg::*;
#(
    parameter int NUM_DEV      = 4,
    parameter int NUM_LINES    = 16,
    parameter logic [7:0] BASE = 8'h60
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     evt_valid,
    input logic                     reg_wr,
    input logic [7:0]               reg_addr,
    input logic [7:0]               reg_wdata,
    input logic [NUM_LINES-1:0]     irq_out,
    input logic [LANES*NUM_DEV-1:0] lvl_flat,
    input logic [LANES*ROUTE_W-1:0] route_flat
);
    logic all_parked;

    // Flag the state where every lane is parked.
    always_comb begin
        all_parked = 1'b1;
        for (int p = 0; p < LANES; p++) begin
            if (route_flat[p*ROUTE_W +: ROUTE_W] < ROUTE_W'(NUM_LINES)) all_parked = 1'b0;
        end
    end

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lvl_flat == '0 && irq_out == '0));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && $past(rst_n)) |=> $stable(lvl_flat));

    a_r2_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && $past(rst_n)) |=> ($countones(lvl_flat ^ $past(lvl_flat)) <= 1));

    a_r3_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_flat == '0) |-> (irq_out == '0));

    a_r6_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        all_parked |-> (irq_out == '0));

    a_r7_line_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= LANES);

    for (genvar p = 0; p < LANES; p++) begin : g_reg_chk
        localparam logic [7:0] MY_ADDR = BASE + 8'(p);

        a_r8_reset_parked: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (route_flat[p*ROUTE_W +: ROUTE_W] == ROUTE_PARKED));

        a_r4_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == MY_ADDR) |=>
            (route_flat[p*ROUTE_W +: ROUTE_W] == $past(reg_wdata)));

        a_r4_write_miss: assert property (@(posedge clk) disable iff (!rst_n)
            (!(reg_wr && reg_addr == MY_ADDR) && $past(rst_n)) |=>
            $stable(route_flat[p*ROUTE_W +: ROUTE_W]));
    end
endmodule

bind pirq_router pirq_router_chk #(
    .NUM_DEV   (NUM_DEV),
    .NUM_LINES (NUM_LINES),
    .BASE      (BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_out    (irq_out),
    .lvl_flat   (lvl_flat),
    .route_flat (route_flat)
);

// File: tb/pirq_router_tb.sv
// Scoreboard bench: driver tasks update a reference model built from the
// requirements and queue the expected outputs; a monitor compares them.
module pirq_router_tb;
    localparam int NDEV  = 4;
    localparam int NLINE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_dev = '0;
    logic [4:0]  evt_slot = '0;
    logic [1:0]  evt_pin = '0;
    logic        evt_level = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] irq_out;

    pirq_router u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dev(evt_dev),
        .evt_slot(evt_slot), .evt_pin(evt_pin), .evt_level(evt_level),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #10ns clk = ~clk;

    typedef struct {
        int          due;
        logic [15:0] irq;
        bit          chk_rd;
        logic [7:0]  rd;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;

    // Reference model
    logic [7:0]      m_route [4];
    logic [NDEV-1:0] m_lvl   [4];

    function automatic logic [15:0] model_irq();
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++) begin
            if (m_route[p] < 8'd16 && m_lvl[p] != '0) r[m_route[p][3:0]] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        if (a >= 8'h60 && a <= 8'h63) return m_route[a - 8'h60];
        return 8'h00;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every item whose cycle has come and compare.
    always @(negedge clk) begin
        if (mon_en) begin
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (irq_out !== it.irq) begin
                    n_bad++;
                    $display("FAIL %s irq_out actual=%h expected=%h", it.tag, irq_out, it.irq);
                end
                if (it.chk_rd) begin
                    n_chk++;
                    if (reg_rdata !== it.rd) begin
                        n_bad++;
                        $display("FAIL %s reg_rdata actual=%h expected=%h", it.tag, reg_rdata, it.rd);
                    end
                end
            end
        end
    end

    task automatic drive_quiet();
        evt_valid = 1'b0;
        reg_wr    = 1'b0;
    endtask

    // Device report: lane = (pin + slot - 1) mod 4 per R1.
    task automatic do_evt(input int dev, input int slot, input int pin,
                          input bit lvl, input string tag);
        item_t it;
        int lane;
        @(posedge clk); #2ns;
        drive_quiet();
        evt_valid = 1'b1; evt_dev = 2'(dev); evt_slot = 5'(slot);
        evt_pin = 2'(pin); evt_level = lvl;
        lane = (pin + slot + 3) % 4;
        m_lvl[lane][dev] = lvl;
        it = '{due: cyc + 1, irq: model_irq(), chk_rd: 1'b0, rd: 8'h00, tag: tag};
        q.push_back(it);
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        item_t it;
        @(posedge clk); #2ns;
        drive_quiet();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a >= 8'h60 && a <= 8'h63) m_route[a - 8'h60] = d;
        it = '{due: cyc + 1, irq: model_irq(), chk_rd: 1'b0, rd: 8'h00, tag: tag};
        q.push_back(it);
    endtask

    task automatic do_rd(input logic [7:0] a, input string tag);
        item_t it;
        @(posedge clk); #2ns;
        drive_quiet();
        reg_addr = a;
        it = '{due: cyc, irq: model_irq(), chk_rd: 1'b1, rd: model_rd(a), tag: tag};
        q.push_back(it);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20ns * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 4; p++) begin
            m_route[p] = 8'h80;
            m_lvl[p]   = '0;
        end
        repeat (3) @(posedge clk);
        #2ns;
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R8 reset state, R5 read-back
        do_rd(8'h60, "R8 reset lane0 parked");
        do_rd(8'h61, "R8 reset lane1 parked");
        do_rd(8'h62, "R8 reset lane2 parked");
        do_rd(8'h63, "R8 reset lane3 parked");

        // R6: level on a parked lane drives nothing
        do_evt(0, 1, 0, 1'b1, "R6 parked lane0 silent");
        // R9: steering alone raises line 5
        do_wr(8'h60, 8'd5, "R9 steer lane0 to line5");
        do_rd(8'h60, "R5 read lane0");
        do_rd(8'h70, "R5 outside window reads zero");

        // R3 / R2: two devices share lane 0
        do_evt(1, 2, 3, 1'b1, "R1 slot2 INTD to lane0");
        do_evt(0, 1, 0, 1'b0, "R3 one sharer left lane0 high");
        do_evt(1, 2, 3, 1'b0, "R3 last sharer drops lane0");

        // R1: slot 0 wraps INTA to lane 3
        do_wr(8'h63, 8'd9, "R4 steer lane3 to line9");
        do_evt(2, 0, 0, 1'b1, "R1 slot0 INTA to lane3");
        // R1: slot 31 wraps INTC to lane 0
        do_evt(3, 31, 2, 1'b1, "R1 slot31 INTC to lane0");
        do_evt(3, 31, 2, 1'b0, "R2 clear slot31 device");

        // R7: two lanes on one line
        do_wr(8'h61, 8'd9, "R7 steer lane1 to line9");
        do_evt(3, 3, 3, 1'b1, "R1 slot3 INTD to lane1");
        do_evt(2, 0, 0, 1'b0, "R7 line9 held by lane1");
        do_evt(2, 1, 1, 1'b1, "R2 same device other lane");
        do_rd(8'h61, "R5 read lane1");

        // R6 boundary: value 16 parks, 15 reaches top line
        do_wr(8'h61, 8'd16, "R6 steer 16 parks lane1");
        do_wr(8'h61, 8'd15, "R9 steer lane1 to line15");

        // R4: write just past the window changes nothing
        do_wr(8'h64, 8'd3, "R4 write 0x64 ignored");
        do_rd(8'h60, "R4 lane0 kept after 0x64");
        do_rd(8'h61, "R4 lane1 kept after 0x64");
        do_rd(8'h62, "R4 lane2 kept after 0x64");
        do_rd(8'h63, "R4 lane3 kept after 0x64");
        do_wr(8'h5F, 8'd2, "R4 write 0x5F ignored");
        do_rd(8'h60, "R4 lane0 kept after 0x5F");

        // R2: quiet cycle keeps every level
        do_rd(8'h62, "R2 idle holds levels");

        repeat (3) @(posedge clk);
        #2ns;
        drive_quiet();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule